// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the word address for a synchronous burst memory. On each qualified clock edge it either captures a fresh base address from the address bus or steps a small internal burst counter, and the output address is the base with its low bits rearranged by that counter. A strap input chooses between a linear order, which counts upward and wraps, and an interleaved order, which XORs the starting low bits with the running count.

The clock is qualified by an active-low enable: while the enable is high every register holds, so the previous cycle is simply stretched. Chip-select decoding happens outside; the block receives a single `sel` flag. A deselected cycle ends the current burst. After that, the next selected access must be a load. An advance request that arrives while deselected, or before a reload, is ignored and raises a violation flag for one enabled cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_out` is 0 and `adv_err` is 0, and no burst is active, so an advance request is refused until the first load.
- R2: On an enabled edge (`cen_n`=0) with `sel`=1 and `ld_adv`=0, the next `addr_out` equals `addr_in`, the burst count restarts at 0, and `adv_err` becomes 0.
- R3: With `mode`=0 (linear), an enabled edge with `sel`=1, `ld_adv`=1 and an active burst adds 1 modulo 4 to the two low bits of `addr_out`, and the upper bits stay unchanged.
- R4: With `mode`=1 (interleaved), the two low bits of `addr_out` equal the loaded low bits XOR the number of advances since the load, modulo 4. For example, a start of 3 gives 3,2,1,0.
- R5: A load followed by four advances brings `addr_out` back to the loaded address, in either order.
- R6: While `cen_n`=1, `addr_out` and `adv_err` hold, whatever the other inputs do.
- R7: An enabled edge with `sel`=0 ends the burst. Advances with `sel`=1 after that are ignored and leave `addr_out` unchanged, each setting `adv_err`, until a load is taken.
- R8: An enabled edge with `sel`=0 and `ld_adv`=1 sets `adv_err` and leaves `addr_out` unchanged.
- R9: `adv_err` returns to 0 on the next enabled edge that is not a refused advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock qualifier, active low; high holds all state |
| ld_adv | input | 1 | 0 = load `addr_in`, 1 = advance the burst |
| sel | input | 1 | Block selected for this cycle (decoded chip select) |
| mode | input | 1 | Burst order strap: 1 = interleaved, 0 = linear |
| addr_in | input | AW | External address for loads |
| addr_out | output | AW | Current access address |
| adv_err | output | 1 | Refused-advance flag |

## Verification
The bench goes after low-bit starts of 1 and 3, where linear and interleaved orders differ. A design with the orders swapped, or with the count not added into the start, would show the wrong sequence, and a wrong counter width would miss the wrap back to the base after four advances. It also stretches cycles with the clock enable high in the middle of a burst; a block that let any register move would skip an address. Deselect-then-advance sequences catch a design that keeps stepping after a deselect, or that fails to raise or clear the violation flag. The random phase mixes all of these with upper-bit changes, to catch a carry leaking out of the counter field.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STEP  = 3'd2,
    OP_DESEL = 3'd3,
    OP_BAD   = 3'd4
  } burst_op_e;

  // Low address bits for a given start and advance count.
  function automatic logic [1:0] order_lo2(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ cnt;
    else            r = start + cnt;
    return r;
  endfunction

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_addr_pkg::*;
(
  input  logic      cen_n,
  input  logic      ld_adv,
  input  logic      sel,
  input  logic      active,
  output burst_op_e op,
  output logic      ev_load,
  output logic      ev_step,
  output logic      ev_desel,
  output logic      ev_bad
);
  logic en;
  assign en = ~cen_n;

  always_comb begin
    op = OP_IDLE;
    if (en) begin
      if (!sel)        op = OP_DESEL;
      else if (!ld_adv) op = OP_LOAD;
      else if (active) op = OP_STEP;
      else             op = OP_BAD;
    end
  end

  assign ev_load  = (op == OP_LOAD);
  assign ev_step  = (op == OP_STEP);
  assign ev_desel = (op == OP_DESEL);
  assign ev_bad   = en & ld_adv & (~sel | ~active);
endmodule

// File: rtl/burst_count.sv
module burst_count #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_load,
  input  logic          ev_step,
  input  logic          ev_desel,
  output logic [CW-1:0] cnt,
  output logic          active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (ev_load) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (ev_step) begin
      cnt    <= CW'(cnt + 1'b1);
    end else if (ev_desel) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_load,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base <= '0;
    else if (ev_load) base <= addr_in;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic          ld_adv,
  input  logic          sel,
  input  logic          mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          adv_err
);
  localparam int CW = 2;
  localparam int UW = AW - CW;

  burst_op_e    op;
  logic         ev_load, ev_step, ev_desel, ev_bad;
  logic [CW-1:0] cnt;
  logic         active;
  logic [AW-1:0] base;

  burst_op_decode u_dec (
    .cen_n(cen_n), .ld_adv(ld_adv), .sel(sel), .active(active),
    .op(op), .ev_load(ev_load), .ev_step(ev_step),
    .ev_desel(ev_desel), .ev_bad(ev_bad)
  );

  burst_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_step(ev_step),
    .ev_desel(ev_desel), .cnt(cnt), .active(active)
  );

  burst_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load),
    .addr_in(addr_in), .base(base)
  );

  // Violation flag: set by a refused advance, cleared by any other enabled edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adv_err <= 1'b0;
    else if (!cen_n) adv_err <= ev_bad;
  end

  logic [UW-1:0] upper;
  assign upper    = base[AW-1:CW];
  assign addr_out = {upper, order_lo2(base[CW-1:0], cnt, mode)};
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen_n,
  input logic          ld_adv,
  input logic          sel,
  input logic          mode,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic          adv_err,
  input logic          ev_step,
  input logic          ev_desel,
  input logic          ev_bad,
  input logic          active
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(addr_out) || !$stable(mode)) && $stable(adv_err));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && sel && !ld_adv) |=> (addr_out == $past(addr_in)) && !adv_err);

  assert_lin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !mode) |=> mode || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

  assert_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> $stable(addr_out[AW-1:2]));

  assert_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> adv_err && $stable(addr_out[AW-1:2]));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> !active);

  assert_errclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !ev_bad) |=> !adv_err);
endmodule

bind burst_addr_gen burst_addr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ld_adv(ld_adv), .sel(sel),
  .mode(mode), .addr_in(addr_in), .addr_out(addr_out), .adv_err(adv_err),
  .ev_step(ev_step), .ev_desel(ev_desel), .ev_bad(ev_bad), .active(active)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cen_n = 1'b1, ld_adv = 1'b0, sel = 1'b0, mode = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          adv_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [AW-1:0] m_base = '0;
  int            m_cnt = 0;
  bit            m_act = 0, m_err = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ld_adv(ld_adv), .sel(sel),
    .mode(mode), .addr_in(addr_in), .addr_out(addr_out), .adv_err(adv_err)
  );

  function automatic logic [AW-1:0] exp_addr();
    int lo, st;
    st = int'(m_base[1:0]);
    if (mode) lo = st ^ (m_cnt % 4);
    else      lo = (st + m_cnt) % 4;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  function automatic void model_edge();
    if (cen_n) return;
    if (!sel) begin m_act = 0; m_err = ld_adv; end
    else if (!ld_adv) begin m_base = addr_in; m_cnt = 0; m_act = 1; m_err = 0; end
    else if (m_act) begin m_cnt = (m_cnt + 1) % 4; m_err = 0; end
    else m_err = 1;
  endfunction

  task automatic check(string req);
    logic [AW-1:0] e;
    e = exp_addr();
    n_chk++;
    if (addr_out !== e || adv_err !== m_err) begin
      n_fail++;
      $display("FAIL %s: addr=%h err=%b expected addr=%h err=%b",
               req, addr_out, adv_err, e, m_err);
    end
  endtask

  task automatic cyc(input bit c, input bit la, input bit s,
                     input logic [AW-1:0] a, input string req);
    cen_n = c; ld_adv = la; sel = s; addr_in = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");
    cyc(0, 1, 1, 16'h0000, "R1 advance before first load refused");
    cyc(0, 0, 1, 16'h0000, "R9 clear after load");

    // linear from start 1
    mode = 0;
    cyc(0, 0, 1, 16'hA5C1, "R2 load");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 16'h0000, "R3 linear step / R5 wrap");
    // linear from start 3 with stretch
    cyc(0, 0, 1, 16'h1233, "R2 load");
    cyc(0, 1, 1, 16'h0000, "R3 linear wrap 3->0");
    cyc(1, 0, 0, 16'hFFFF, "R6 hold on cen_n high");
    cyc(1, 1, 1, 16'hFFFF, "R6 hold on cen_n high");
    cyc(0, 1, 1, 16'h0000, "R3 resume after stretch");

    // interleaved from start 3 and 1
    mode = 1;
    cyc(0, 0, 1, 16'h7FF3, "R2 load");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 16'h0000, "R4 interleaved / R5 wrap");
    cyc(0, 0, 1, 16'h0101, "R2 load");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 16'h0000, "R4 interleaved start 1");

    // deselect handling
    cyc(0, 1, 0, 16'h0000, "R8 advance while deselected");
    cyc(1, 0, 1, 16'h0000, "R6 err held during stretch");
    cyc(0, 1, 1, 16'h0000, "R7 advance after deselect refused");
    cyc(0, 1, 1, 16'h0000, "R7 still refused");
    cyc(0, 0, 0, 16'h0000, "R9 deselect clears err");
    cyc(0, 0, 1, 16'hBEEF, "R7 reload after deselect");
    cyc(0, 1, 1, 16'h0000, "R4 step after reload");

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit c, la, s;
      c  = ($urandom % 5) == 0;
      la = ($urandom % 4) != 0;
      s  = ($urandom % 8) != 0;
      if (($urandom % 64) == 0) mode = ~mode;
      cyc(c, la, s, 16'($urandom), "R2-R9 random mix");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule